// File: doc/BRIEF.md
# Resumable NMI Trap Controller

This block is the machine-mode trap-control slice that lets a hart take a resumable non-maskable interrupt without disturbing the ordinary trap save registers. It keeps its own set of four CSRs: a scratch word, a saved PC, a cause word and a status word. A set-only enable bit gates the RNMI path. When an RNMI is taken, the block records the interrupted context in its own registers and steers the PC to a fixed RNMI vector. A dedicated return strobe restores the interrupted context.

While the enable bit is clear, the hart is inside the RNMI window. In that window, an exception raised in machine mode is sent to a separate fixed vector. Every other trap goes to the ordinary trap vector supplied from outside. The block also produces the privilege that loads and stores should use, so that the MPRV override has no effect inside the window. It reports the next PC, privilege and virtualization bit, an MPRV clear, and a redirect flag, all combinationally in the cycle of the event. Its own CSR state changes at the following clock edge.

Top module: `rnmi_trap_ctrl`

## Requirements
- R1: The CSR port decodes the scratch register at 0x740, the saved PC at 0x741, the cause register at 0x742 and the status register at 0x744, and it asserts `csr_hit` for those addresses. Any other address gives `csr_hit`=0 and read data 0.
- R2: The status register holds the previous privilege in bits 12:11, the previous landing-pad flag in bit 9, the previous virtualization flag in bit 7 and the enable in bit 3; all other bits read as 0. A write of privilege code 2 (reserved) leaves the previous-privilege field unchanged.
- R3: The enable bit resets to 0. A CSR write with bit 3 set makes it 1, and a CSR write with bit 3 clear leaves it unchanged.
- R4: While the enable bit is 0, `nmi_req` is ignored: it causes no redirect and changes no CSR.
- R5: With the enable bit at 1, `nmi_req` outranks exceptions, interrupts and the return strobe. It raises `redirect` with `next_pc` = RNMI_VEC, `next_priv` = 3 (machine) and `next_virt` = 0.
- R6: At the clock edge of an RNMI entry, the block updates its CSRs as follows:
  - the saved PC takes `cur_pc` with its low ALIGN_LSB bits cleared;
  - the cause register takes bit XLEN-1 set with `nmi_code` in the low bits;
  - the previous-privilege, previous-virtualization and previous-landing-pad fields take `cur_priv`, `cur_virt` and `cur_elp`;
  - the enable bit becomes 0.
- R7: An exception (`exc_valid`) redirects to machine mode. It goes to RNMI_EXC_VEC when `cur_priv` is 3 and the enable bit is 0, and to `trap_vec` otherwise. Exceptions outrank interrupts, and an interrupt goes to `trap_vec`.
- R8: The return strobe in machine mode, with no trap pending, raises `redirect`. It sets `next_pc` to the saved PC and `next_priv` to the previous privilege. It sets `next_virt` to the previous virtualization flag when that privilege is not 3, and to 0 otherwise. It raises `mprv_clr` exactly when the previous privilege is not 3, and it sets the enable bit to 1 at the next edge.
- R9: The return strobe below machine mode raises `illegal`, gives no redirect and changes no CSR.
- R10: The saved PC clears its low ALIGN_LSB bits on CSR writes and on the read made by the return.
- R11: `eff_ls_priv` equals `mpp_i` when `mprv_i`=1 and the enable bit is 1; otherwise it equals `cur_priv`.
- R12: The scratch register is a full-width read/write register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_req | input | 1 | Resumable NMI request |
| nmi_code | input | CODE_W | Cause code of the RNMI |
| irq_valid | input | 1 | Ordinary interrupt ready to be taken |
| exc_valid | input | 1 | Exception raised by the current instruction |
| trap_vec | input | XLEN | Ordinary trap target PC |
| mnret | input | 1 | RNMI return instruction strobe |
| cur_pc | input | XLEN | PC of the current instruction |
| cur_priv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| cur_virt | input | 1 | Current virtualization bit |
| cur_elp | input | 1 | Current landing-pad expected flag |
| mprv_i | input | 1 | MPRV bit of the ordinary status |
| mpp_i | input | 2 | MPP field of the ordinary status |
| csr_addr | input | 12 | CSR address |
| csr_we | input | 1 | CSR write enable |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data |
| csr_hit | output | 1 | Address belongs to this block |
| redirect | output | 1 | PC redirect this cycle |
| next_pc | output | XLEN | Target PC when redirecting |
| next_priv | output | 2 | Privilege after the redirect |
| next_virt | output | 1 | Virtualization bit after the redirect |
| mprv_clr | output | 1 | Clear MPRV this cycle |
| illegal | output | 1 | Return strobe executed below machine mode |
| eff_ls_priv | output | 2 | Effective privilege for loads and stores |

## Verification
The assertions check on every cycle the properties that hold cycle by cycle:
- the enable bit falls only on an RNMI entry;
- a masked request never redirects;
- a taken request always goes to the RNMI vector in machine mode;
- a machine-mode exception inside the window reaches the separate vector;
- a return in machine mode re-enables, and a return below machine mode is flagged and not redirected;
- the MPRV override is inert while the window is open.

The directed scenarios are needed for behaviour that shows only across several operations: exact field placement in the status image, and WARL handling of the reserved privilege code. They also cover the values saved on entry and restored by a later return, alignment masking on both the write and the return paths, and priority when several requests arrive together.

// File: rtl/rnmi_pkg.sv
package rnmi_pkg;

    localparam logic [11:0] ADDR_SCRATCH = 12'h740;
    localparam logic [11:0] ADDR_EPC     = 12'h741;
    localparam logic [11:0] ADDR_CAUSE   = 12'h742;
    localparam logic [11:0] ADDR_STATUS  = 12'h744;

    localparam logic [1:0] PRIV_U = 2'b00;
    localparam logic [1:0] PRIV_S = 2'b01;
    localparam logic [1:0] PRIV_RSV = 2'b10;
    localparam logic [1:0] PRIV_M = 2'b11;

    localparam int unsigned ST_PP_LO = 11;
    localparam int unsigned ST_PELP  = 9;
    localparam int unsigned ST_PV    = 7;
    localparam int unsigned ST_NMIE  = 3;
    localparam int unsigned ST_W     = 13;

    typedef struct packed {
        logic [1:0] pp;
        logic       pelp;
        logic       pv;
        logic       nmie;
    } rnmi_status_t;

    typedef struct packed {
        logic       redirect;
        logic [1:0] priv;
        logic       virt;
        logic       mprv_clr;
    } rnmi_step_t;

    function automatic logic [ST_W-1:0] status_image(input rnmi_status_t s);
        logic [ST_W-1:0] img;
        img = '0;
        img[ST_PP_LO +: 2] = s.pp;
        img[ST_PELP]       = s.pelp;
        img[ST_PV]         = s.pv;
        img[ST_NMIE]       = s.nmie;
        return img;
    endfunction

endpackage

// File: rtl/rnmi_csr_bank.sv
module rnmi_csr_bank
    import rnmi_pkg::*;
#(
    parameter int unsigned XLEN        = 32,
    parameter int unsigned CODE_W      = 8,
    parameter int unsigned ALIGN_LSB   = 1,
    parameter bit          REPORT_CODE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [11:0]       csr_addr,
    input  logic              csr_we,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic [XLEN-1:0]   csr_rdata,
    output logic              csr_hit,
    input  logic              enter,
    input  logic              leave,
    input  logic [XLEN-1:0]   ent_pc,
    input  logic [1:0]        ent_priv,
    input  logic              ent_virt,
    input  logic              ent_elp,
    input  logic [CODE_W-1:0] ent_code,
    output logic              nmie,
    output logic [XLEN-1:0]   saved_pc,
    output logic [1:0]        prev_priv,
    output logic              prev_virt
);

    localparam logic [XLEN-1:0] PC_MASK = {XLEN{1'b1}} << ALIGN_LSB;
    localparam int unsigned     PAD_W   = XLEN - 1 - CODE_W;

    logic [XLEN-1:0]   scratch_q;
    logic [XLEN-1:0]   epc_q;
    logic [XLEN-1:0]   cause_q;
    rnmi_status_t      stat_q;
    logic [CODE_W-1:0] code_kept;

    generate
        if (REPORT_CODE) begin : g_code
            assign code_kept = ent_code;
        end else begin : g_nocode
            assign code_kept = '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scratch_q <= '0;
            epc_q     <= '0;
            cause_q   <= '0;
            stat_q    <= '0;
        end else begin
            if (csr_we && csr_addr == ADDR_SCRATCH) begin
                scratch_q <= csr_wdata;
            end
            if (enter) begin
                epc_q       <= ent_pc & PC_MASK;
                cause_q     <= {1'b1, {PAD_W{1'b0}}, code_kept};
                stat_q.pp   <= ent_priv;
                stat_q.pv   <= ent_virt;
                stat_q.pelp <= ent_elp;
                stat_q.nmie <= 1'b0;
            end else if (leave) begin
                stat_q.nmie <= 1'b1;
            end else if (csr_we) begin
                case (csr_addr)
                    ADDR_EPC:   epc_q   <= csr_wdata & PC_MASK;
                    ADDR_CAUSE: cause_q <= csr_wdata;
                    ADDR_STATUS: begin
                        if (csr_wdata[ST_PP_LO +: 2] != PRIV_RSV) begin
                            stat_q.pp <= csr_wdata[ST_PP_LO +: 2];
                        end
                        stat_q.pelp <= csr_wdata[ST_PELP];
                        stat_q.pv   <= csr_wdata[ST_PV];
                        stat_q.nmie <= stat_q.nmie | csr_wdata[ST_NMIE];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        csr_hit   = 1'b1;
        csr_rdata = '0;
        case (csr_addr)
            ADDR_SCRATCH: csr_rdata = scratch_q;
            ADDR_EPC:     csr_rdata = epc_q & PC_MASK;
            ADDR_CAUSE:   csr_rdata = cause_q;
            ADDR_STATUS:  csr_rdata = XLEN'(status_image(stat_q));
            default:      csr_hit   = 1'b0;
        endcase
    end

    assign nmie      = stat_q.nmie;
    assign saved_pc  = epc_q & PC_MASK;
    assign prev_priv = stat_q.pp;
    assign prev_virt = stat_q.pv;

endmodule

// File: rtl/rnmi_trap_pick.sv
module rnmi_trap_pick
    import rnmi_pkg::*;
#(
    parameter int unsigned     XLEN         = 32,
    parameter logic [XLEN-1:0] RNMI_VEC     = '0,
    parameter logic [XLEN-1:0] RNMI_EXC_VEC = '0
) (
    input  logic            nmi_req,
    input  logic            irq_valid,
    input  logic            exc_valid,
    input  logic            mnret,
    input  logic            nmie,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [1:0]      cur_priv,
    input  logic            cur_virt,
    input  logic [XLEN-1:0] trap_vec,
    input  logic [XLEN-1:0] saved_pc,
    input  logic [1:0]      prev_priv,
    input  logic            prev_virt,
    output logic            take_nmi,
    output logic            do_ret,
    output logic            illegal,
    output logic [XLEN-1:0] next_pc,
    output rnmi_step_t      step
);

    logic in_m;
    logic other_trap;

    always_comb begin
        in_m       = (cur_priv == PRIV_M);
        take_nmi   = nmi_req && nmie;
        other_trap = take_nmi || exc_valid || irq_valid;
        illegal    = mnret && !in_m && !other_trap;
        do_ret     = 1'b0;
        next_pc    = cur_pc;
        step       = '{redirect: 1'b0, priv: cur_priv, virt: cur_virt, mprv_clr: 1'b0};
        if (take_nmi) begin
            next_pc = RNMI_VEC;
            step    = '{redirect: 1'b1, priv: PRIV_M, virt: 1'b0, mprv_clr: 1'b0};
        end else if (exc_valid) begin
            next_pc = (in_m && !nmie) ? RNMI_EXC_VEC : trap_vec;
            step    = '{redirect: 1'b1, priv: PRIV_M, virt: 1'b0, mprv_clr: 1'b0};
        end else if (irq_valid) begin
            next_pc = trap_vec;
            step    = '{redirect: 1'b1, priv: PRIV_M, virt: 1'b0, mprv_clr: 1'b0};
        end else if (mnret && in_m) begin
            do_ret  = 1'b1;
            next_pc = saved_pc;
            step    = '{redirect: 1'b1, priv: prev_priv,
                        virt: (prev_priv != PRIV_M) && prev_virt,
                        mprv_clr: (prev_priv != PRIV_M)};
        end
    end

endmodule

// File: rtl/rnmi_trap_ctrl.sv
module rnmi_trap_ctrl
    import rnmi_pkg::*;
#(
    parameter int unsigned     XLEN         = 32,
    parameter int unsigned     CODE_W       = 8,
    parameter int unsigned     ALIGN_LSB    = 1,
    parameter bit              REPORT_CODE  = 1'b1,
    parameter logic [XLEN-1:0] RNMI_VEC     = XLEN'(32'h0000_0100),
    parameter logic [XLEN-1:0] RNMI_EXC_VEC = XLEN'(32'h0000_0200)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              nmi_req,
    input  logic [CODE_W-1:0] nmi_code,
    input  logic              irq_valid,
    input  logic              exc_valid,
    input  logic [XLEN-1:0]   trap_vec,
    input  logic              mnret,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [1:0]        cur_priv,
    input  logic              cur_virt,
    input  logic              cur_elp,
    input  logic              mprv_i,
    input  logic [1:0]        mpp_i,
    input  logic [11:0]       csr_addr,
    input  logic              csr_we,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic [XLEN-1:0]   csr_rdata,
    output logic              csr_hit,
    output logic              redirect,
    output logic [XLEN-1:0]   next_pc,
    output logic [1:0]        next_priv,
    output logic              next_virt,
    output logic              mprv_clr,
    output logic              illegal,
    output logic [1:0]        eff_ls_priv
);

    logic            nmie;
    logic [XLEN-1:0] saved_pc;
    logic [1:0]      prev_priv;
    logic            prev_virt;
    logic            take_nmi;
    logic            do_ret;
    rnmi_step_t      step;

    rnmi_csr_bank #(
        .XLEN(XLEN), .CODE_W(CODE_W), .ALIGN_LSB(ALIGN_LSB), .REPORT_CODE(REPORT_CODE)
    ) i_bank (
        .clk(clk), .rst(rst),
        .csr_addr(csr_addr), .csr_we(csr_we), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .csr_hit(csr_hit),
        .enter(take_nmi), .leave(do_ret),
        .ent_pc(cur_pc), .ent_priv(cur_priv), .ent_virt(cur_virt),
        .ent_elp(cur_elp), .ent_code(nmi_code),
        .nmie(nmie), .saved_pc(saved_pc), .prev_priv(prev_priv), .prev_virt(prev_virt)
    );

    rnmi_trap_pick #(
        .XLEN(XLEN), .RNMI_VEC(RNMI_VEC), .RNMI_EXC_VEC(RNMI_EXC_VEC)
    ) i_pick (
        .nmi_req(nmi_req), .irq_valid(irq_valid), .exc_valid(exc_valid), .mnret(mnret),
        .nmie(nmie), .cur_pc(cur_pc), .cur_priv(cur_priv), .cur_virt(cur_virt),
        .trap_vec(trap_vec), .saved_pc(saved_pc), .prev_priv(prev_priv),
        .prev_virt(prev_virt), .take_nmi(take_nmi), .do_ret(do_ret),
        .illegal(illegal), .next_pc(next_pc), .step(step)
    );

    assign redirect    = step.redirect;
    assign next_priv   = step.priv;
    assign next_virt   = step.virt;
    assign mprv_clr    = step.mprv_clr;
    assign eff_ls_priv = (nmie && mprv_i) ? mpp_i : cur_priv;

endmodule

// File: rtl/rnmi_trap_chk.sv
module rnmi_trap_chk #(
    parameter int unsigned     XLEN         = 32,
    parameter int unsigned     ALIGN_LSB    = 1,
    parameter logic [XLEN-1:0] RNMI_VEC     = '0,
    parameter logic [XLEN-1:0] RNMI_EXC_VEC = '0
) (
    input logic            clk,
    input logic            rst,
    input logic            nmi_req,
    input logic            irq_valid,
    input logic            exc_valid,
    input logic            mnret,
    input logic [XLEN-1:0] cur_pc,
    input logic [1:0]      cur_priv,
    input logic            nmie,
    input logic [XLEN-1:0] saved_pc,
    input logic [1:0]      prev_priv,
    input logic            redirect,
    input logic [XLEN-1:0] next_pc,
    input logic [1:0]      next_priv,
    input logic            illegal,
    input logic [1:0]      eff_ls_priv
);

    localparam logic [XLEN-1:0] PC_MASK = {XLEN{1'b1}} << ALIGN_LSB;

    a_r3_enable_drops_on_entry_only: assert property (@(posedge clk) disable iff (rst)
        $fell(nmie) |-> $past(nmi_req));

    a_r4_masked_request_quiet: assert property (@(posedge clk) disable iff (rst)
        (!nmie && nmi_req && !exc_valid && !irq_valid && !mnret) |-> !redirect);

    a_r5_taken_request_vector: assert property (@(posedge clk) disable iff (rst)
        (nmie && nmi_req) |-> (redirect && next_pc == RNMI_VEC && next_priv == 2'b11));

    a_r6_entry_saves_context: assert property (@(posedge clk) disable iff (rst)
        (nmie && nmi_req) |=> (!nmie && saved_pc == ($past(cur_pc) & PC_MASK)
                                && prev_priv == $past(cur_priv)));

    a_r7_window_exception_vector: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && !nmie && cur_priv == 2'b11) |-> (redirect && next_pc == RNMI_EXC_VEC));

    a_r8_return_reenables: assert property (@(posedge clk) disable iff (rst)
        (mnret && cur_priv == 2'b11 && !(nmie && nmi_req) && !exc_valid && !irq_valid)
        |=> nmie);

    a_r9_low_priv_return_flagged: assert property (@(posedge clk) disable iff (rst)
        (mnret && cur_priv != 2'b11 && !nmi_req && !exc_valid && !irq_valid)
        |-> (illegal && !redirect));

    a_r11_mprv_inert_in_window: assert property (@(posedge clk) disable iff (rst)
        !nmie |-> eff_ls_priv == cur_priv);

endmodule

bind rnmi_trap_ctrl rnmi_trap_chk #(
    .XLEN(XLEN), .ALIGN_LSB(ALIGN_LSB), .RNMI_VEC(RNMI_VEC), .RNMI_EXC_VEC(RNMI_EXC_VEC)
) i_chk (
    .clk(clk), .rst(rst), .nmi_req(nmi_req), .irq_valid(irq_valid),
    .exc_valid(exc_valid), .mnret(mnret), .cur_pc(cur_pc), .cur_priv(cur_priv),
    .nmie(nmie), .saved_pc(saved_pc), .prev_priv(prev_priv), .redirect(redirect),
    .next_pc(next_pc), .next_priv(next_priv), .illegal(illegal), .eff_ls_priv(eff_ls_priv)
);

// File: tb/test_rnmi_trap_ctrl.sv
module test_rnmi_trap_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nmi_req = 1'b0;
    logic [7:0]  nmi_code = '0;
    logic        irq_valid = 1'b0;
    logic        exc_valid = 1'b0;
    logic [31:0] trap_vec = 32'h300;
    logic        mnret = 1'b0;
    logic [31:0] cur_pc = '0;
    logic [1:0]  cur_priv = 2'b11;
    logic        cur_virt = 1'b0;
    logic        cur_elp = 1'b0;
    logic        mprv_i = 1'b0;
    logic [1:0]  mpp_i = 2'b00;
    logic [11:0] csr_addr = '0;
    logic        csr_we = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        csr_hit;
    logic        redirect;
    logic [31:0] next_pc;
    logic [1:0]  next_priv;
    logic        next_virt;
    logic        mprv_clr;
    logic        illegal;
    logic [1:0]  eff_ls_priv;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    rnmi_trap_ctrl i_rnmi_trap_ctrl (
        .clk(clk), .rst(rst), .nmi_req(nmi_req), .nmi_code(nmi_code),
        .irq_valid(irq_valid), .exc_valid(exc_valid), .trap_vec(trap_vec),
        .mnret(mnret), .cur_pc(cur_pc), .cur_priv(cur_priv), .cur_virt(cur_virt),
        .cur_elp(cur_elp), .mprv_i(mprv_i), .mpp_i(mpp_i), .csr_addr(csr_addr),
        .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .csr_hit(csr_hit), .redirect(redirect), .next_pc(next_pc),
        .next_priv(next_priv), .next_virt(next_virt), .mprv_clr(mprv_clr),
        .illegal(illegal), .eff_ls_priv(eff_ls_priv)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic quiet();
        nmi_req = 1'b0; irq_valid = 1'b0; exc_valid = 1'b0; mnret = 1'b0;
        csr_we = 1'b0; mprv_i = 1'b0;
    endtask

    task automatic csr_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        quiet();
        csr_addr = a; csr_wdata = d; csr_we = 1'b1;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic csr_rd(input logic [11:0] a, output logic [31:0] d, output logic h);
        @(negedge clk);
        quiet();
        csr_addr = a;
        #2;
        d = csr_rdata; h = csr_hit;
    endtask

    task automatic t_reset();
        logic [31:0] d; logic h;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        csr_rd(12'h744, d, h);
        chk("R3 status after reset", d, 32'h0);
        chk("R1 status hit", {31'b0, h}, 32'h1);
        chk("R3 no redirect idle", {31'b0, redirect}, 32'h0);
        csr_rd(12'h743, d, h);
        chk("R1 unmapped hit", {31'b0, h}, 32'h0);
        chk("R1 unmapped data", d, 32'h0);
    endtask

    task automatic t_masked();
        logic [31:0] d; logic h;
        @(negedge clk);
        cur_priv = 2'b00; cur_pc = 32'h44; nmi_req = 1'b1; mprv_i = 1'b1; mpp_i = 2'b11;
        #2;
        chk("R4 masked request redirect", {31'b0, redirect}, 32'h0);
        chk("R11 mprv inert while disabled", {30'b0, eff_ls_priv}, 32'h0);
        csr_rd(12'h741, d, h);
        chk("R4 saved pc untouched", d, 32'h0);
        csr_rd(12'h744, d, h);
        chk("R4 status untouched", d, 32'h0);
        @(negedge clk);
        cur_priv = 2'b11; exc_valid = 1'b1; irq_valid = 1'b1;
        #2;
        chk("R7 window exception vector", next_pc, 32'h200);
        chk("R7 window exception redirect", {31'b0, redirect}, 32'h1);
    endtask

    task automatic t_csr();
        logic [31:0] d; logic h;
        csr_wr(12'h740, 32'hDEAD_BEEF);
        csr_rd(12'h740, d, h);
        chk("R12 scratch readback", d, 32'hDEAD_BEEF);
        csr_wr(12'h741, 32'h0000_1235);
        csr_rd(12'h741, d, h);
        chk("R10 saved pc write mask", d, 32'h0000_1234);
        csr_wr(12'h744, 32'hFFFF_FFFF);
        csr_rd(12'h744, d, h);
        chk("R2 status all ones image", d, 32'h0000_1A88);
        csr_wr(12'h744, 32'h0);
        csr_rd(12'h744, d, h);
        chk("R3 zero write keeps enable", d, 32'h0000_0008);
        csr_wr(12'h744, 32'h0000_1000);
        csr_rd(12'h744, d, h);
        chk("R2 reserved privilege ignored", d, 32'h0000_0008);
    endtask

    task automatic t_entry();
        logic [31:0] d; logic h;
        @(negedge clk);
        quiet();
        cur_priv = 2'b01; cur_virt = 1'b1; cur_elp = 1'b1; cur_pc = 32'h8000_0011;
        nmi_code = 8'd5; nmi_req = 1'b1; exc_valid = 1'b1; irq_valid = 1'b1; mnret = 1'b1;
        mprv_i = 1'b1; mpp_i = 2'b00;
        #2;
        chk("R5 entry redirect", {31'b0, redirect}, 32'h1);
        chk("R5 entry vector", next_pc, 32'h100);
        chk("R5 entry privilege", {30'b0, next_priv}, 32'h3);
        chk("R5 entry virt", {31'b0, next_virt}, 32'h0);
        chk("R11 mprv applies when enabled", {30'b0, eff_ls_priv}, 32'h0);
        csr_rd(12'h741, d, h);
        chk("R6 saved pc", d, 32'h8000_0010);
        csr_rd(12'h742, d, h);
        chk("R6 cause", d, 32'h8000_0005);
        csr_rd(12'h744, d, h);
        chk("R6 status after entry", d, 32'h0000_0A80);
        @(negedge clk);
        cur_virt = 1'b0; cur_elp = 1'b0;
        cur_priv = 2'b11; exc_valid = 1'b1; nmi_req = 1'b1;
        #2;
        chk("R7 exception inside window", next_pc, 32'h200);
        chk("R4 request masked inside window", {30'b0, next_priv}, 32'h3);
    endtask

    task automatic t_returns();
        logic [31:0] d; logic h;
        @(negedge clk);
        quiet();
        cur_priv = 2'b01; mnret = 1'b1;
        #2;
        chk("R9 illegal flagged", {31'b0, illegal}, 32'h1);
        chk("R9 no redirect", {31'b0, redirect}, 32'h0);
        csr_rd(12'h744, d, h);
        chk("R9 status unchanged", d, 32'h0000_0A80);
        @(negedge clk);
        cur_priv = 2'b11; mnret = 1'b1;
        #2;
        chk("R8 return redirect", {31'b0, redirect}, 32'h1);
        chk("R8 return pc", next_pc, 32'h8000_0010);
        chk("R8 return privilege", {30'b0, next_priv}, 32'h1);
        chk("R8 return virt", {31'b0, next_virt}, 32'h1);
        chk("R8 return mprv clear", {31'b0, mprv_clr}, 32'h1);
        csr_rd(12'h744, d, h);
        chk("R8 enable set by return", d, 32'h0000_0A88);
        @(negedge clk);
        exc_valid = 1'b1;
        #2;
        chk("R7 exception outside window", next_pc, 32'h300);
        @(negedge clk);
        exc_valid = 1'b0; irq_valid = 1'b1;
        #2;
        chk("R7 interrupt vector", next_pc, 32'h300);
        csr_wr(12'h744, 32'h0000_1880);
        csr_wr(12'h741, 32'h0000_2003);
        @(negedge clk);
        quiet();
        cur_priv = 2'b11; mnret = 1'b1;
        #2;
        chk("R10 return pc masked", next_pc, 32'h0000_2002);
        chk("R8 return to machine privilege", {30'b0, next_priv}, 32'h3);
        chk("R8 return to machine virt", {31'b0, next_virt}, 32'h0);
        chk("R8 return to machine no mprv clear", {31'b0, mprv_clr}, 32'h0);
        @(negedge clk);
        quiet();
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_masked();
        t_csr();
        t_entry();
        t_returns();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule